// File: doc/BRIEF.md
# Translation Storage Buffer Pointer Generator

After a TLB miss, software or a hardware walker needs the memory address of the translation storage buffer slot that may hold the missing translation. This block forms that address from the tag-access value (faulting virtual address in the upper bits, 13-bit context in the low bits), a pointer select that chooses the primary or the secondary page-size pointer, and the base and configuration registers supplied from outside.

Two modes exist. In legacy mode a single base register is used, and the page-size code equals the pointer select. In hypervisor mode the context picks one of two configuration registers, which supplies a 3-bit page-size code. The context and the pointer select together pick one of four base registers. The pointer is available combinationally on `ptr_now`. A registered copy, `ptr_reg`, is loaded one cycle after a request and then held.

Top module: `tsb_ptr_gen`

## Requirements
- R1: The low 4 bits of the selected base register give the buffer size `s`, and bit 12 is the split flag `p`. Output bits at positions 13+s+p and above come from the base register. Bits below that position come from the shifted virtual address.
- R2: The virtual-address part is the full tag-access value shifted right by 3·ps+9, where ps is the page-size code.
- R3: When the split flag is set, output bit 13+s equals the pointer select: 0 for the primary pointer and 1 for the secondary pointer.
- R4: Output bits [3:0] are always zero.
- R5: In legacy mode (`hv_mode`=0), `legacy_base` is used and the page-size code equals `ptr_sel`. With `ptr_sel`=0 the code is 0 (8 KB pages), and with `ptr_sel`=1 it is 1 (64 KB pages).
- R6: In hypervisor mode the context is `tag_access[12:0]`. A zero context selects `ctx_cfg0`, and a nonzero context selects `ctx_cfg1`.
- R7: In hypervisor mode the page-size code is bits [2:0] of the selected configuration for the primary pointer, and bits [10:8] for the secondary pointer.
- R8: In hypervisor mode the base register index is `ptr_sel` in bit 0, with bit 1 set when the context is nonzero. Index 0..3 maps to `hv_base0`..`hv_base3`.
- R9: `ptr_now` reflects the current inputs in the same cycle, with no register in the path.
- R10: `ptr_reg` takes the value of `ptr_now` at the clock edge where `req_valid` is high, and `out_valid` is high for the following cycle. Without a request, `ptr_reg` holds its value and `out_valid` is low.
- R11: While `rst_n` is low, `ptr_reg` is 0 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Capture request for the registered pointer |
| hv_mode | input | 1 | 1 = hypervisor mode, 0 = legacy mode |
| ptr_sel | input | 1 | 0 = primary pointer, 1 = secondary pointer |
| tag_access | input | 64 | Faulting virtual address with context in [12:0] |
| legacy_base | input | 64 | Base register for legacy mode |
| hv_base0 | input | 64 | Hypervisor base, zero context, primary |
| hv_base1 | input | 64 | Hypervisor base, zero context, secondary |
| hv_base2 | input | 64 | Hypervisor base, nonzero context, primary |
| hv_base3 | input | 64 | Hypervisor base, nonzero context, secondary |
| ctx_cfg0 | input | 64 | Page-size configuration for zero context |
| ctx_cfg1 | input | 64 | Page-size configuration for nonzero context |
| ptr_now | output | 64 | Combinational pointer |
| ptr_reg | output | 64 | Registered pointer |
| out_valid | output | 1 | High for one cycle after a captured request |

## Verification
The main function is driven in both modes and with both pointer selects. The legacy vectors vary the size field and the split flag, so a wrong mask width or a missed forced bit shows up as a changed bit near 13+s. The hypervisor vectors pair zero and nonzero contexts with configurations whose two page-size fields differ, so a swapped configuration, a swapped field or a wrong base index each gives a different address. A hand-computed legacy case pins the absolute shift amount, and a hold sequence checks that the registered copy ignores input changes made without a request.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  localparam int AW     = 64;
  localparam int CTX_W  = 13;
  localparam int SZ_W   = 4;
  localparam int PS_W   = 3;
  localparam int SPLIT_BIT = 12;
  localparam int LOW_CLR = 4;
  localparam int HI_PS_LSB = 8;

  // base-region mask: ones from bit 13+size(+split) upward
  function automatic logic [AW-1:0] region_mask(input logic [SZ_W-1:0] sz,
                                                input logic split);
    logic [AW-1:0] m;
    m = {AW{1'b1}} << (CTX_W + int'(sz));
    if (split) m = m << 1;
    return m;
  endfunction

  // virtual-address part aligned to the buffer entry grid
  function automatic logic [AW-1:0] va_part(input logic [AW-1:0] tag,
                                            input logic [PS_W-1:0] ps);
    return tag >> (3 * int'(ps) + 9);
  endfunction
endpackage

// File: rtl/tsb_src_sel.sv
module tsb_src_sel
  import tsb_pkg::*;
(
  input  logic          hv_mode,
  input  logic          ptr_sel,
  input  logic [AW-1:0] tag_access,
  input  logic [AW-1:0] legacy_base,
  input  logic [AW-1:0] hv_base [4],
  input  logic [AW-1:0] ctx_cfg [2],
  output logic [AW-1:0] sel_base,
  output logic [PS_W-1:0] sel_ps,
  output logic [1:0]    base_idx,
  output logic          ctx_nz
);
  logic [AW-1:0] cfg_w;

  always_comb begin
    ctx_nz   = |tag_access[CTX_W-1:0];
    cfg_w    = ctx_cfg[ctx_nz];
    base_idx = {ctx_nz, ptr_sel};
    if (hv_mode) begin
      sel_base = hv_base[base_idx];
      sel_ps   = ptr_sel ? cfg_w[HI_PS_LSB +: PS_W] : cfg_w[PS_W-1:0];
    end else begin
      sel_base = legacy_base;
      sel_ps   = {{(PS_W-1){1'b0}}, ptr_sel};
    end
  end
endmodule

// File: rtl/tsb_addr_calc.sv
module tsb_addr_calc
  import tsb_pkg::*;
(
  input  logic [AW-1:0]   base,
  input  logic [PS_W-1:0] ps,
  input  logic            ptr_sel,
  input  logic [AW-1:0]   tag_access,
  output logic [AW-1:0]   ptr,
  output logic            split,
  output logic [SZ_W-1:0] size
);
  logic [AW-1:0] mask_w;
  logic [AW-1:0] va_w;

  always_comb begin
    size   = base[SZ_W-1:0];
    split  = base[SPLIT_BIT];
    mask_w = region_mask(size, split);
    va_w   = va_part(tag_access, ps);
    if (split) va_w[CTX_W + int'(size)] = ptr_sel;
    ptr = (base & mask_w) | (va_w & ~mask_w);
    ptr[LOW_CLR-1:0] = '0;
  end
endmodule

// File: rtl/tsb_ptr_gen.sv
module tsb_ptr_gen
  import tsb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          hv_mode,
  input  logic          ptr_sel,
  input  logic [63:0]   tag_access,
  input  logic [63:0]   legacy_base,
  input  logic [63:0]   hv_base0,
  input  logic [63:0]   hv_base1,
  input  logic [63:0]   hv_base2,
  input  logic [63:0]   hv_base3,
  input  logic [63:0]   ctx_cfg0,
  input  logic [63:0]   ctx_cfg1,
  output logic [63:0]   ptr_now,
  output logic [63:0]   ptr_reg,
  output logic          out_valid
);
  logic [AW-1:0]   hv_bank [4];
  logic [AW-1:0]   cfg_bank [2];
  logic [AW-1:0]   base_w;
  logic [PS_W-1:0] ps_w;
  logic [1:0]      idx_w;
  logic            ctx_nz_w;
  logic            split_w;
  logic [SZ_W-1:0] size_w;

  assign hv_bank[0] = hv_base0;
  assign hv_bank[1] = hv_base1;
  assign hv_bank[2] = hv_base2;
  assign hv_bank[3] = hv_base3;
  assign cfg_bank[0] = ctx_cfg0;
  assign cfg_bank[1] = ctx_cfg1;

  tsb_src_sel u_sel (
    .hv_mode(hv_mode), .ptr_sel(ptr_sel), .tag_access(tag_access),
    .legacy_base(legacy_base), .hv_base(hv_bank), .ctx_cfg(cfg_bank),
    .sel_base(base_w), .sel_ps(ps_w), .base_idx(idx_w), .ctx_nz(ctx_nz_w)
  );

  tsb_addr_calc u_calc (
    .base(base_w), .ps(ps_w), .ptr_sel(ptr_sel), .tag_access(tag_access),
    .ptr(ptr_now), .split(split_w), .size(size_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_reg   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) ptr_reg <= ptr_now;
    end
  end

  // R10
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (out_valid && ptr_reg == $past(ptr_now)));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && $stable(ptr_reg)));
  // R4
  low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ptr_reg[LOW_CLR-1:0] == '0);
  // R3
  split_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    split_w |-> ptr_now[CTX_W + int'(size_w)] == ptr_sel);
  // R8
  hv_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hv_mode |-> (idx_w[1] == (tag_access[CTX_W-1:0] != '0) && idx_w[0] == ptr_sel));
  // R6
  ctx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_access[CTX_W-1:0] == '0) |-> !ctx_nz_w);
endmodule

// File: tb/sim_tsb_ptr_gen.sv
module sim_tsb_ptr_gen;
  logic clk = 0, rst_n = 0, req_valid = 0, hv_mode = 0, ptr_sel = 0;
  logic [63:0] tag_access = '0, legacy_base = '0;
  logic [63:0] hv_base0, hv_base1, hv_base2, hv_base3, ctx_cfg0, ctx_cfg1;
  logic [63:0] ptr_now, ptr_reg;
  logic out_valid;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tsb_ptr_gen u0 (.*);

  // bench-side model: decides each output bit position on its own
  function automatic logic [63:0] model(input logic hv, input logic sel,
      input logic [63:0] tag, input logic [63:0] lb, input logic [63:0] b0,
      input logic [63:0] b1, input logic [63:0] b2, input logic [63:0] b3,
      input logic [63:0] c0, input logic [63:0] c1);
    logic [63:0] b, c, r;
    int ps, sz, sp, cut, sh;
    bit nz;
    nz = (tag[12:0] != 0);
    c  = nz ? c1 : c0;
    if (!hv) begin b = lb; ps = sel; end
    else begin
      case ({nz, sel})
        2'b00: b = b0; 2'b01: b = b1; 2'b10: b = b2; default: b = b3;
      endcase
      ps = sel ? int'(c[10:8]) : int'(c[2:0]);
    end
    sz = int'(b[3:0]); sp = int'(b[12]);
    cut = 13 + sz + sp;
    sh = 3 * ps + 9;
    for (int i = 0; i < 64; i++) begin
      if (i < 4) r[i] = 1'b0;
      else if (i >= cut) r[i] = b[i];
      else if (sp == 1 && i == 13 + sz) r[i] = sel;
      else r[i] = (i + sh < 64) ? tag[i + sh] : 1'b0;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // {hv, sel, tag_access, legacy_base, ctx_cfg0, ctx_cfg1}
  localparam int NV = 10;
  localparam logic [257:0] VEC [NV] = '{
    {1'b0, 1'b0, 64'h0000_0123_4567_89AB, 64'hFFF0_0000_0000_0000, 64'h0, 64'h0},
    {1'b0, 1'b1, 64'h0000_0123_4567_89AB, 64'hFFF0_0000_0000_0003, 64'h0, 64'h0},
    {1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_1000, 64'h0, 64'h0},
    {1'b0, 1'b1, 64'h0000_0000_0000_0000, 64'h8000_0000_0000_100F, 64'h0, 64'h0},
    {1'b0, 1'b1, 64'hDEAD_BEEF_CAFE_F00D, 64'h1234_5678_9ABC_1005, 64'h0, 64'h0},
    {1'b1, 1'b0, 64'h0000_7777_8888_0000, 64'h0, 64'h0000_0000_0000_0201, 64'h0000_0000_0000_0503},
    {1'b1, 1'b1, 64'h0000_7777_8888_0000, 64'h0, 64'h0000_0000_0000_0201, 64'h0000_0000_0000_0503},
    {1'b1, 1'b0, 64'h0000_7777_8888_0042, 64'h0, 64'h0000_0000_0000_0201, 64'h0000_0000_0000_0503},
    {1'b1, 1'b1, 64'h0000_7777_8888_1FFF, 64'h0, 64'h0000_0000_0000_0201, 64'h0000_0000_0000_0503},
    {1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_E001, 64'h0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0700}
  };

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] exp;
    hv_base0 = 64'h0000_1111_0000_0002;
    hv_base1 = 64'h0000_2222_0000_1003;
    hv_base2 = 64'h0000_3333_0000_0005;
    hv_base3 = 64'h0000_4444_0000_1000;
    ctx_cfg0 = '0; ctx_cfg1 = '0;
    req_valid = 1;
    repeat (3) @(negedge clk);
    // R11 reset state while a request is asserted
    check("R11 ptr_reg in reset", ptr_reg, 64'h0);
    check("R11 out_valid in reset", {63'h0, out_valid}, 64'h0);
    req_valid = 0; rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      {hv_mode, ptr_sel, tag_access, legacy_base, ctx_cfg0, ctx_cfg1} = VEC[v];
      #1;
      exp = model(hv_mode, ptr_sel, tag_access, legacy_base, hv_base0, hv_base1,
                  hv_base2, hv_base3, ctx_cfg0, ctx_cfg1);
      // R1 R2 R3 R4 R5 R6 R7 R8, seen combinationally (R9)
      check(hv_mode ? "R1/R2/R3/R4/R6/R7/R8/R9 hv vector" : "R1/R2/R3/R4/R5/R9 legacy vector",
            ptr_now, exp);
      req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      check("R10 ptr_reg after request", ptr_reg, exp);
      check("R10 out_valid after request", {63'h0, out_valid}, 64'h1);
    end

    // R2 R4 R5 hand value: legacy 8 KB, size 0, no split
    hv_mode = 0; ptr_sel = 0;
    legacy_base = 64'hABCD_0000_0000_0000;
    tag_access  = 64'h0000_0000_1234_5ABC;
    #1;
    check("R2/R4/R5 hand-computed pointer", ptr_now, 64'hABCD_0000_0000_1A20);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    exp = ptr_reg;
    // R10 hold: change inputs without a request
    tag_access = 64'h5555_AAAA_5555_AAAA; legacy_base = 64'h0;
    @(negedge clk);
    check("R10 ptr_reg held without request", ptr_reg, exp);
    check("R10 out_valid low without request", {63'h0, out_valid}, 64'h0);
    // R3 split with 64 KB pointer forces bit 13 set
    legacy_base = 64'h0000_0000_0000_1000; ptr_sel = 1; tag_access = 64'h0;
    #1;
    check("R3 split forced bit", ptr_now, 64'h0000_0000_0000_2000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule